// File: doc/BRIEF.md
# Dual-Bank Floating-Point Register File with Mode Register

This block holds the operand storage of a floating-point unit: two physical banks of sixteen 32-bit registers and one 32-bit mode/status register. Software sees the banks as a front bank, which serves arithmetic operands, and a back bank, which holds extended operands. One mode bit swaps the roles of the two physical banks in a single cycle, so a context can change its working set without copying any data. A second mode bit switches moves from single 32-bit words to 64-bit even/odd register pairs.

The register file has two combinational read ports and one synchronous write port. Each port is addressed by a logical index plus a front/back selector, and the current bank mapping applies. The mode register is written as a whole through its own port. A `set_flags` input lets the datapath OR sticky exception flags into it. The precision, denormal and rounding fields are decoded and exported as plain mode pins for a downstream datapath, which performs all arithmetic. Every port accepts one access per cycle without back-pressure, so the ports carry only a strobe and no ready signal.

Top module: `fp_bank_regfile`

## Requirements
- R1: On reset the mode register reads 0x00040001, and every register of both banks reads 0.
- R2: Mode register bits 31..22 always read 0, and a write to them is ignored. A write stores bits 21..0 exactly as given.
- R3: A mode register write becomes visible after the next clock edge. A register read or write in the same cycle uses the mapping that held before the mode write.
- R4: With bit 21 clear, front indices reach physical bank 0 and back indices reach bank 1. With bit 21 set, the two roles are exchanged.
- R5: With bit 20 clear (single mode), a write stores `wr_data[31:0]` at the index, and a read returns {32'h0, register}.
- R6: With bit 20 set (pair mode), a write to an even index n stores `wr_data[63:32]` in n and `wr_data[31:0]` in n+1. A read at n or n+1 returns {register n&~1, register n|1}.
- R7: In pair mode, a write with an odd index drives `addr_error` high in that cycle and changes no register. In single mode `addr_error` stays low.
- R8: `illegal_mode` is high exactly while mode bits 20 and 19 are both set.
- R9: The mode pins follow the mode register: `bank_swap` = bit 21, `pair_mode` = bit 20, `prec_dbl` = bit 19, `denorm_zero` = bit 18, `round_mode` = bits 1..0.
- R10: In a cycle with no mode write, `set_flags` is ORed into the sticky flag field at bits 6..2. A mode write in the same cycle wins, and `set_flags` is dropped for that cycle.
- R11: Both read ports are combinational and independent. Data written at one edge is returned by a read of the same location right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_back | input | 1 | Read port 0 selects the back bank when 1 |
| rd0_idx | input | 4 | Read port 0 logical index |
| rd0_data | output | 64 | Read port 0 data |
| rd1_back | input | 1 | Read port 1 selects the back bank when 1 |
| rd1_idx | input | 4 | Read port 1 logical index |
| rd1_data | output | 64 | Read port 1 data |
| wr_valid | input | 1 | Write strobe |
| wr_back | input | 1 | Write targets the back bank when 1 |
| wr_idx | input | 4 | Write logical index |
| wr_data | input | 64 | Write data (low word only in single mode) |
| addr_error | output | 1 | Odd pair-mode write rejected this cycle |
| ctl_wr_en | input | 1 | Mode register write strobe |
| ctl_wr_data | input | 32 | Mode register write value |
| set_flags | input | 5 | Sticky flags to OR into bits 6..2 |
| ctl_rd_data | output | 32 | Mode register value |
| bank_swap | output | 1 | Bank roles exchanged |
| pair_mode | output | 1 | 64-bit pair moves |
| prec_dbl | output | 1 | Double-precision mode |
| denorm_zero | output | 1 | Denormals flushed to zero |
| round_mode | output | 2 | Rounding mode field |
| illegal_mode | output | 1 | Reserved mode combination active |

## Verification
The bench builds the block with its default values of sixteen registers per bank and 32-bit words. With so few indices, random traffic hits every register of both physical banks under both mappings, and every even/odd pair in pair mode. Mode writes are mixed into the same cycles as register accesses, so the old-mapping rule and the priority of a direct write over sticky flags are exercised repeatedly.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int CTL_W     = 32;
  localparam int B_SWAP    = 21;
  localparam int B_PAIR    = 20;
  localparam int B_DBL     = 19;
  localparam int B_DAZ     = 18;
  localparam int CAUSE_LSB = 12;
  localparam int CAUSE_W   = 6;
  localparam int EN_LSB    = 7;
  localparam int EN_W      = 5;
  localparam int FLG_LSB   = 2;
  localparam int FLG_W     = 5;
  localparam int RND_LSB   = 0;
  localparam int RND_W     = 2;
  localparam logic [CTL_W-1:0] CTL_RST   = 32'h0004_0001;
  localparam logic [CTL_W-1:0] CTL_WMASK = 32'h003F_FFFF;
endpackage

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic [FLG_W-1:0] set_flags,
  output logic [CTL_W-1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
    end else if (wr_en) begin
      ctl_q <= wr_data & CTL_WMASK;
    end else begin
      ctl_q[FLG_LSB +: FLG_W] <= ctl_q[FLG_LSB +: FLG_W] | set_flags;
    end
  end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank #(
  parameter int NREG = 16,
  parameter int W    = 32,
  parameter int NRD  = 2,
  localparam int NPAIR = NREG / 2,
  localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_even,
  input  logic                    we_odd,
  input  logic [PW-1:0]           wpair,
  input  logic [W-1:0]            wd_even,
  input  logic [W-1:0]            wd_odd,
  input  logic [NRD-1:0][PW-1:0]  rpair,
  output logic [NRD-1:0][W-1:0]   r_even,
  output logic [NRD-1:0][W-1:0]   r_odd
);
  logic [W-1:0] mem_e [NPAIR];
  logic [W-1:0] mem_o [NPAIR];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic hit;
    assign hit = (wpair == PW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_e[p] <= '0;
        mem_o[p] <= '0;
      end else begin
        if (we_even && hit) mem_e[p] <= wd_even;
        if (we_odd && hit)  mem_o[p] <= wd_odd;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign r_even[r] = mem_e[rpair[r]];
    assign r_odd[r]  = mem_o[rpair[r]];
  end
endmodule

// File: rtl/fp_bank_regfile.sv
module fp_bank_regfile
  import fpr_pkg::*;
#(
  parameter int NREG = 16,
  parameter int W    = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int PW   = (IDXW > 1) ? IDXW - 1 : 1,
  localparam int NRD  = 2,
  localparam int NBANK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd0_back,
  input  logic [IDXW-1:0]   rd0_idx,
  output logic [2*W-1:0]    rd0_data,
  input  logic              rd1_back,
  input  logic [IDXW-1:0]   rd1_idx,
  output logic [2*W-1:0]    rd1_data,
  input  logic              wr_valid,
  input  logic              wr_back,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [2*W-1:0]    wr_data,
  output logic              addr_error,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  input  logic [FLG_W-1:0]  set_flags,
  output logic [CTL_W-1:0]  ctl_rd_data,
  output logic              bank_swap,
  output logic              pair_mode,
  output logic              prec_dbl,
  output logic              denorm_zero,
  output logic [RND_W-1:0]  round_mode,
  output logic              illegal_mode
);
  logic [CTL_W-1:0] ctl_q;

  fpr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr_en),
    .wr_data   (ctl_wr_data),
    .set_flags (set_flags),
    .ctl_q     (ctl_q)
  );

  assign ctl_rd_data  = ctl_q;
  assign bank_swap    = ctl_q[B_SWAP];
  assign pair_mode    = ctl_q[B_PAIR];
  assign prec_dbl     = ctl_q[B_DBL];
  assign denorm_zero  = ctl_q[B_DAZ];
  assign round_mode   = ctl_q[RND_LSB +: RND_W];
  assign illegal_mode = ctl_q[B_PAIR] & ctl_q[B_DBL];

  // write decode, using the mapping held before any same-cycle mode write
  logic wr_ok, wbank, we_e, we_o;
  logic [W-1:0] wd_e, wd_o;
  assign addr_error = wr_valid & pair_mode & wr_idx[0];
  assign wr_ok      = wr_valid & ~addr_error;
  assign wbank      = wr_back ^ bank_swap;
  assign we_e       = wr_ok & (pair_mode | ~wr_idx[0]);
  assign we_o       = wr_ok & (pair_mode |  wr_idx[0]);
  assign wd_e       = pair_mode ? wr_data[2*W-1:W] : wr_data[W-1:0];
  assign wd_o       = wr_data[W-1:0];

  logic [NRD-1:0]           rbank;
  logic [NRD-1:0][IDXW-1:0] ridx;
  logic [NRD-1:0][PW-1:0]   rpair;
  logic [NRD-1:0][2*W-1:0]  rdata;
  logic [NRD-1:0][W-1:0]    re [NBANK];
  logic [NRD-1:0][W-1:0]    ro [NBANK];

  assign ridx[0]  = rd0_idx;
  assign ridx[1]  = rd1_idx;
  assign rbank[0] = rd0_back ^ bank_swap;
  assign rbank[1] = rd1_back ^ bank_swap;
  assign rd0_data = rdata[0];
  assign rd1_data = rdata[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    fpr_bank #(.NREG(NREG), .W(W), .NRD(NRD)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_even (we_e && (wbank == 1'(b))),
      .we_odd  (we_o && (wbank == 1'(b))),
      .wpair   (wr_idx[IDXW-1:1]),
      .wd_even (wd_e),
      .wd_odd  (wd_o),
      .rpair   (rpair),
      .r_even  (re[b]),
      .r_odd   (ro[b])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rport
    logic [W-1:0] ev, od;
    assign rpair[r] = ridx[r][IDXW-1:1];
    assign ev = re[rbank[r]][r];
    assign od = ro[rbank[r]][r];
    assign rdata[r] = pair_mode ? {ev, od}
                                : {{W{1'b0}}, (ridx[r][0] ? od : ev)};
  end
endmodule

// File: rtl/fpr_chk.sv
module fpr_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic [IDXW-1:0] wr_idx,
  input logic            ctl_wr_en,
  input logic [31:0]     ctl_wr_data,
  input logic [4:0]      set_flags,
  input logic [31:0]     ctl_rd_data,
  input logic            addr_error,
  input logic            illegal_mode,
  input logic            pair_mode,
  input logic            prec_dbl
);
  AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_data[31:22] == 10'h0); // R2

  AST_CTL_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_rd_data[21:0] == $past(ctl_wr_data[21:0])); // R3

  AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr_en && set_flags == 5'h0) |=> $stable(ctl_rd_data)); // R3

  AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr_en && set_flags != 5'h0) |=>
      ((ctl_rd_data[6:2] & $past(set_flags)) == $past(set_flags))); // R10

  AST_ERR_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_error |-> (wr_valid && pair_mode && wr_idx[0])); // R7

  AST_ERR_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |-> !addr_error); // R7

  AST_ILLEGAL_COMBO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode == (pair_mode && prec_dbl)); // R8
endmodule

bind fp_bank_regfile fpr_chk #(.IDXW(IDXW)) u_chk (.*);

// File: tb/test_fp_bank_regfile.sv
module test_fp_bank_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rd0_back = 0, rd1_back = 0, wr_valid = 0, wr_back = 0, ctl_wr_en = 0;
  logic [3:0]  rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0;
  logic [31:0] ctl_wr_data = 0;
  logic [4:0]  set_flags = 0;
  logic [63:0] rd0_data, rd1_data;
  logic [31:0] ctl_rd_data;
  logic addr_error, bank_swap, pair_mode, prec_dbl, denorm_zero, illegal_mode;
  logic [1:0] round_mode;

  fp_bank_regfile i_fp_bank_regfile (.*);

  int n_run = 0, n_fail = 0;
  logic [31:0] m_mem [2][16];
  logic [31:0] m_ctl;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_rd(int idx, bit back);
    int b = int'(back ^ m_ctl[21]);
    if (m_ctl[20]) return {m_mem[b][idx & 14], m_mem[b][idx | 1]};
    return {32'h0, m_mem[b][idx]};
  endfunction

  task automatic compare_all;
    chk("R2 mode reg", 64'(ctl_rd_data), 64'(m_ctl));
    chk("R4 read port 0", rd0_data, m_rd(int'(rd0_idx), rd0_back));
    chk("R11 read port 1", rd1_data, m_rd(int'(rd1_idx), rd1_back));
    chk("R7 addr_error", 64'(addr_error), 64'(wr_valid & m_ctl[20] & wr_idx[0]));
    chk("R8 illegal_mode", 64'(illegal_mode), 64'(m_ctl[20] & m_ctl[19]));
    chk("R9 mode pins", 64'({bank_swap, pair_mode, prec_dbl, denorm_zero, round_mode}),
        64'({m_ctl[21:18], m_ctl[1:0]}));
  endtask

  task automatic model_edge;
    int b = int'(wr_back ^ m_ctl[21]);
    int i = int'(wr_idx);
    if (wr_valid && !(m_ctl[20] && wr_idx[0])) begin
      if (m_ctl[20]) begin
        m_mem[b][i] = wr_data[63:32];
        m_mem[b][i + 1] = wr_data[31:0];
      end else m_mem[b][i] = wr_data[31:0];
    end
    if (ctl_wr_en) m_ctl = ctl_wr_data & 32'h003F_FFFF;
    else m_ctl[6:2] = m_ctl[6:2] | set_flags;
  endtask

  task automatic tick;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle;
    wr_valid = 0; ctl_wr_en = 0; set_flags = 0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  logic [31:0] keep;
  initial begin
    m_ctl = 32'h0004_0001;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 16; i++) m_mem[b][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 mode reset value", 64'(ctl_rd_data), 64'h0004_0001);
    chk("R1 register reset", rd0_data, 64'h0);
    // fill both banks in single mode
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        wr_valid = 1; wr_back = b[0]; wr_idx = i[3:0];
        wr_data = {32'hDEAD_0000, 32'h1000_0000 + 32'(b * 256 + i)};
        tick();
      end
    idle();
    rd0_idx = 7; rd0_back = 0; rd1_idx = 7; rd1_back = 1;
    #1;
    chk("R5 single read front", rd0_data, {32'h0, 32'h1000_0007});
    chk("R5 single read back", rd1_data, {32'h0, 32'h1000_0107});
    tick();
    // swap in the same cycle as a read and a write
    ctl_wr_en = 1; ctl_wr_data = 32'h0024_0001;
    rd0_idx = 3; rd0_back = 0;
    wr_valid = 1; wr_back = 0; wr_idx = 9; wr_data = 64'h5555_1234;
    #1;
    chk("R3 same-cycle read uses old map", rd0_data, {32'h0, 32'h1000_0003});
    tick();
    idle();
    rd0_idx = 9; rd0_back = 1; rd1_idx = 3; rd1_back = 0;
    #1;
    chk("R3 same-cycle write used old map", rd0_data, 64'h5555_1234);
    chk("R4 swapped front reaches bank 1", rd1_data, {32'h0, 32'h1000_0103});
    tick();
    // reserved bits and illegal combination
    ctl_wr_en = 1; ctl_wr_data = 32'hFFFF_FFFF;
    tick(); idle();
    #1;
    chk("R2 reserved bits dropped", 64'(ctl_rd_data), 64'h003F_FFFF);
    chk("R8 illegal combination", 64'(illegal_mode), 64'h1);
    tick();
    // mode pins
    ctl_wr_en = 1; ctl_wr_data = 32'h000C_0003;
    tick(); idle();
    #1;
    chk("R9 precision denormal rounding", 64'({prec_dbl, denorm_zero, round_mode, illegal_mode}),
        64'(5'b11110));
    tick();
    // pair mode
    ctl_wr_en = 1; ctl_wr_data = 32'h0010_0000;
    tick(); idle();
    wr_valid = 1; wr_back = 0; wr_idx = 4; wr_data = 64'hAAAA_0001_BBBB_0002;
    tick(); idle();
    rd0_idx = 4; rd0_back = 0; rd1_idx = 5; rd1_back = 0;
    #1;
    chk("R6 pair read even", rd0_data, 64'hAAAA_0001_BBBB_0002);
    chk("R6 pair read odd index", rd1_data, 64'hAAAA_0001_BBBB_0002);
    wr_valid = 1; wr_idx = 5; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    #1;
    chk("R7 odd pair write flags error", 64'(addr_error), 64'h1);
    tick(); idle();
    #1;
    chk("R7 odd pair write suppressed", rd0_data, 64'hAAAA_0001_BBBB_0002);
    tick();
    // sticky flags
    set_flags = 5'b00101; tick();
    set_flags = 5'b10000; tick(); idle();
    #1;
    chk("R10 flags accumulate", 64'(ctl_rd_data[6:2]), 64'(5'b10101));
    ctl_wr_en = 1; ctl_wr_data = 32'h0000_0000; set_flags = 5'b11111;
    tick(); idle();
    #1;
    chk("R10 direct write wins", 64'(ctl_rd_data[6:2]), 64'h0);
    // write then read-after-edge
    keep = m_mem[0][2];
    wr_valid = 1; wr_back = 0; wr_idx = 2; wr_data = 64'h0000_0000_CAFE_F00D;
    rd0_idx = 2; rd0_back = 0;
    #1;
    chk("R11 read before edge", rd0_data, {32'h0, keep});
    tick(); idle();
    #1;
    chk("R11 read after edge", rd0_data, 64'h0000_0000_CAFE_F00D);
    tick();
    // random traffic
    for (int n = 0; n < 600; n++) begin
      rd0_idx = 4'($urandom); rd0_back = 1'($urandom);
      rd1_idx = 4'($urandom); rd1_back = 1'($urandom);
      wr_valid = 1'($urandom); wr_back = 1'($urandom); wr_idx = 4'($urandom);
      wr_data = {$urandom, $urandom};
      ctl_wr_en = ($urandom % 8) == 0;
      ctl_wr_data = $urandom;
      set_flags = ($urandom % 4 == 0) ? 5'($urandom) : 5'h0;
      tick();
    end
    idle();
    tick();
    summary();
    $finish;
  end
endmodule